// File: doc/BRIEF.md
# Sound-Processor Address Decoder with Banked Main-Bus Window

This block sits between an 8-bit sound processor and the resources that processor can reach. Every access the processor makes is classified by its 16-bit address and steered to one of five places: a local 8 KiB work RAM, an FM synthesis chip, a programmable sound generator (PSG), a 9-bit bank register, or a 32 KiB window that opens onto the 24-bit main-processor bus. Accesses that land nowhere read back as zero and have no effect when written.

The bank register is loaded serially. Each write to the bank page shifts the register one place toward bit 0 and drops bit 0 of the written byte into bit 8. After nine such writes the register holds a complete bank number, which becomes bits [23:15] of every main-bus address the window produces. A window access raises a request and stalls the sound processor until the main bus acknowledges it. A 16-bit access is carried out as two byte accesses in succession: the low byte at the given address, then the high byte at the next address.

The sequencer has four named states. SQ_IDLE waits for a read or write strobe; the transition "start" moves it to SQ_LO. SQ_LO performs the low-byte access and stays there while a window access is unacknowledged ("stall"). Once the byte is complete it takes "split" to SQ_HI when the access is 16 bits wide, or "finish" to SQ_DONE when it is not. SQ_HI performs the high-byte access, with the same "stall", and then takes "finish". SQ_DONE pulses completion and takes "release" back to SQ_IDLE.

Top module: `sndbus_decoder`

## Requirements
- R1: Byte addresses whose bits [15:13] are 3'b010 (0x4000–0x5FFF) select the FM chip. fm_cs is raised only while fm_enable is 1, and fm_we is raised as well for writes. A read returns fm_rdata when fm_enable is 1 and 0 when it is 0.
- R2: A write to a byte address equal to 0x7F11 once bits 1 and 2 are masked off (0x7F11, 0x7F13, 0x7F15, 0x7F17) pulses psg_we for one cycle when psg_enable is 1, and does not pulse it when psg_enable is 0. A read of these addresses returns 0. Neighbouring addresses such as 0x7F10 and 0x7F19 do not reach the PSG.
- R3: The bank register resets to 0. A write to any byte address whose bits [15:8] are 0x60 replaces it with {wdata bit 0, bank[8:1]}. Nothing else changes it.
- R4: Byte addresses 0x8000–0xFFFF raise mbus_req with mbus_addr = {bank, address[14:0]} and mbus_we equal to the write strobe. The request, and the address with it, is held until the cycle in which mbus_ack is 1. A read returns the mbus_rdata sampled in that cycle.
- R5: Byte addresses 0x0000–0x3FFF raise ram_cs for one cycle with ram_addr = address[12:0], so 0x0000–0x1FFF and 0x2000–0x3FFF reach the same locations. ram_we follows the write strobe, and a read returns ram_rdata.
- R6: The FM range is decoded ahead of the PSG and bank checks. Reads of unmapped addresses (0x6000–0x7FFF apart from the PSG addresses, including the bank page) return 0 and raise no select.
- R7: When cpu_wide is 1, the low byte (cpu_wdata[7:0] / cpu_rdata[7:0]) is accessed at cpu_addr, and the high byte ([15:8]) at cpu_addr+1, which wraps from 0xFFFF to 0x0000. Each byte is decoded on its own.
- R8: Completion timing: cpu_done is a single-cycle pulse in the cycle after the last byte completes. A local byte access takes exactly one cycle. cpu_rdata is valid while cpu_done is 1, and the high byte reads 0 when the access is a single byte.
- R9: At most one of ram_cs, fm_cs, psg_we and mbus_req is active in any cycle, and none is active outside an access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Sound-processor address |
| cpu_wdata | input | 16 | Write data; low byte first |
| cpu_rd | input | 1 | Read strobe, held until cpu_done |
| cpu_wr | input | 1 | Write strobe, held until cpu_done |
| cpu_wide | input | 1 | 1 = 16-bit access, split into two bytes |
| cpu_rdata | output | 16 | Read data, valid with cpu_done |
| cpu_done | output | 1 | Access complete pulse |
| fm_enable | input | 1 | FM chip present |
| psg_enable | input | 1 | PSG present |
| dbus_wdata | output | 8 | Byte being written to RAM, FM, PSG or main bus |
| ram_cs | output | 1 | Local RAM select |
| ram_we | output | 1 | Local RAM write |
| ram_addr | output | 13 | Local RAM index |
| ram_rdata | input | 8 | Local RAM read data (combinational) |
| fm_cs | output | 1 | FM chip select |
| fm_we | output | 1 | FM chip write |
| fm_addr | output | 2 | FM register port select (address bits [1:0]) |
| fm_rdata | input | 8 | FM status byte |
| psg_we | output | 1 | PSG write strobe |
| mbus_req | output | 1 | Main-bus request |
| mbus_we | output | 1 | Main-bus write |
| mbus_addr | output | 24 | Main-bus byte address |
| mbus_ack | input | 1 | Main-bus acknowledge |
| mbus_rdata | input | 8 | Main-bus read data, valid with mbus_ack |

## Verification
The assertions take for granted that the processor holds cpu_addr, cpu_wdata, cpu_wide and its strobe steady from the strobe's first cycle until cpu_done, never raises both strobes together, and lowers the strobe in the cycle of cpu_done. They also assume that mbus_ack is only raised while mbus_req is high. The bench keeps to these rules by driving one access at a time from a task, on the falling edge: it raises a single strobe, holds every request input, pulses the acknowledge for exactly one cycle after a chosen number of stall cycles, and drops the strobe as soon as it sees completion.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;

    // Destination of one byte access
    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_FM   = 3'd2,
        TGT_PSG  = 3'd3,
        TGT_BANK = 3'd4,
        TGT_WIN  = 3'd5
    } tgt_e;

    // Access sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LO   = 2'd1,
        SQ_HI   = 2'd2,
        SQ_DONE = 2'd3
    } seq_e;

    // Sound-processor address map (fixed by the processor's 16-bit space)
    localparam int unsigned CPU_AW      = 16;
    localparam logic [2:0]  FM_TOP3     = 3'b010;
    localparam logic [15:0] PSG_MASK    = 16'hFFF9;
    localparam logic [15:0] PSG_MATCH   = 16'h7F11;
    localparam logic [7:0]  BANK_PAGE   = 8'h60;

endpackage

// File: rtl/sndbus_region.sv
module sndbus_region
    import sndbus_pkg::*;
(
    input  logic [CPU_AW-1:0] byte_addr,
    output tgt_e              tgt
);

    logic is_fm;
    logic is_psg;
    logic is_bank;
    logic is_win;
    logic is_ram;

    assign is_fm   = (byte_addr[15:13] == FM_TOP3);
    assign is_psg  = ((byte_addr & PSG_MASK) == PSG_MATCH);
    assign is_bank = (byte_addr[15:8] == BANK_PAGE);
    assign is_win  = byte_addr[15];
    assign is_ram  = (byte_addr[15:14] == 2'b00);

    // Fixed priority: FM first, then PSG, bank page, window, RAM
    always_comb begin
        if (is_fm)
            tgt = TGT_FM;
        else if (is_psg)
            tgt = TGT_PSG;
        else if (is_bank)
            tgt = TGT_BANK;
        else if (is_win)
            tgt = TGT_WIN;
        else if (is_ram)
            tgt = TGT_RAM;
        else
            tgt = TGT_NONE;
    end

endmodule

// File: rtl/sndbus_bank.sv
module sndbus_bank #(
    parameter int unsigned BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bit_in,
    output logic [BANK_W-1:0] bank
);

    // Serial loader: each load moves every bit one place down, new bit at top
    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
        if (i == BANK_W - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank[i] <= 1'b0;
                else if (load)
                    bank[i] <= bit_in;
            end
        end else begin : g_low
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank[i] <= 1'b0;
                else if (load)
                    bank[i] <= bank[i+1];
            end
        end
    end

    // R3: without a load the bank value does not move
    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank));

    // R3: the bit written lands at the top
    assert_bank_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bank[BANK_W-1] == $past(bit_in));

endmodule

// File: rtl/sndbus_seq.sv
module sndbus_seq
    import sndbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          cpu_wide,
    input  logic          win_hit,
    input  logic          mbus_ack,
    input  logic [DW-1:0] byte_rdata,
    output logic          acc_on,
    output logic          acc_hi,
    output logic          cpu_done,
    output logic [2*DW-1:0] cpu_rdata
);

    seq_e state_q;
    seq_e state_d;
    logic step;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    // A byte is complete at once unless it waits on the main bus
    assign step = !win_hit || mbus_ack;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (cpu_rd || cpu_wr) state_d = SQ_LO;          // start
            SQ_LO:   if (step) state_d = cpu_wide ? SQ_HI : SQ_DONE; // split / finish
            SQ_HI:   if (step) state_d = SQ_DONE;                    // finish
            SQ_DONE: state_d = SQ_IDLE;                              // release
            default: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        acc_on   = 1'b0;
        acc_hi   = 1'b0;
        cpu_done = 1'b0;
        unique case (state_q)
            SQ_IDLE: ;
            SQ_LO:   acc_on = 1'b1;
            SQ_HI:   begin acc_on = 1'b1; acc_hi = 1'b1; end
            SQ_DONE: cpu_done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (state_q == SQ_IDLE && (cpu_rd || cpu_wr)) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (state_q == SQ_LO && step && cpu_rd) begin
                lo_q <= byte_rdata;
            end else if (state_q == SQ_HI && step && cpu_rd) begin
                hi_q <= byte_rdata;
            end
        end
    end

    assign cpu_rdata = {hi_q, lo_q};

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R7: the high-byte phase exists only for wide accesses
    assert_hi_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hi |-> cpu_wide);

    // R4: a stalled window byte keeps the sequencer in the same phase
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_on && win_hit && !mbus_ack) |=> (acc_on && $stable(acc_hi)));

endmodule

// File: rtl/sndbus_decoder.sv
module sndbus_decoder
    import sndbus_pkg::*;
#(
    parameter int unsigned RAM_AW = 13,
    parameter int unsigned BANK_W = 9,
    parameter int unsigned DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [2*DW-1:0]      cpu_wdata,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic                 cpu_wide,
    output logic [2*DW-1:0]      cpu_rdata,
    output logic                 cpu_done,
    input  logic                 fm_enable,
    input  logic                 psg_enable,
    output logic [DW-1:0]        dbus_wdata,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic [RAM_AW-1:0]    ram_addr,
    input  logic [DW-1:0]        ram_rdata,
    output logic                 fm_cs,
    output logic                 fm_we,
    output logic [1:0]           fm_addr,
    input  logic [DW-1:0]        fm_rdata,
    output logic                 psg_we,
    output logic                 mbus_req,
    output logic                 mbus_we,
    output logic [BANK_W+14:0]   mbus_addr,
    input  logic                 mbus_ack,
    input  logic [DW-1:0]        mbus_rdata
);

    localparam int unsigned WIN_AW = 15;

    logic [15:0]       byte_addr;
    tgt_e              tgt;
    logic              acc_on;
    logic              acc_hi;
    logic              win_hit;
    logic              bank_load;
    logic [BANK_W-1:0] bank;
    logic [DW-1:0]     byte_rdata;

    // Byte address of the current phase; the high byte wraps within 16 bits
    assign byte_addr  = acc_hi ? (cpu_addr + 16'd1) : cpu_addr;
    assign dbus_wdata = acc_hi ? cpu_wdata[2*DW-1:DW] : cpu_wdata[DW-1:0];

    sndbus_region u_region (
        .byte_addr (byte_addr),
        .tgt       (tgt)
    );

    assign win_hit = acc_on && (tgt == TGT_WIN);

    sndbus_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wide   (cpu_wide),
        .win_hit    (win_hit),
        .mbus_ack   (mbus_ack),
        .byte_rdata (byte_rdata),
        .acc_on     (acc_on),
        .acc_hi     (acc_hi),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata)
    );

    assign bank_load = acc_on && cpu_wr && (tgt == TGT_BANK);

    sndbus_bank #(.BANK_W(BANK_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bank_load),
        .bit_in (dbus_wdata[0]),
        .bank   (bank)
    );

    // Selects and strobes
    always_comb begin
        ram_cs   = 1'b0;
        ram_we   = 1'b0;
        fm_cs    = 1'b0;
        fm_we    = 1'b0;
        psg_we   = 1'b0;
        mbus_req = 1'b0;
        mbus_we  = 1'b0;
        if (acc_on) begin
            unique case (tgt)
                TGT_RAM: begin
                    ram_cs = 1'b1;
                    ram_we = cpu_wr;
                end
                TGT_FM: begin
                    fm_cs = fm_enable;
                    fm_we = fm_enable && cpu_wr;
                end
                TGT_PSG:  psg_we = psg_enable && cpu_wr;
                TGT_WIN: begin
                    mbus_req = 1'b1;
                    mbus_we  = cpu_wr;
                end
                TGT_BANK: ;
                TGT_NONE: ;
                default:  ;
            endcase
        end
    end

    assign ram_addr  = byte_addr[RAM_AW-1:0];
    assign fm_addr   = byte_addr[1:0];
    assign mbus_addr = {bank, byte_addr[WIN_AW-1:0]};

    // Read data of the current byte
    always_comb begin
        unique case (tgt)
            TGT_RAM: byte_rdata = ram_rdata;
            TGT_FM:  byte_rdata = fm_enable ? fm_rdata : '0;
            TGT_WIN: byte_rdata = mbus_rdata;
            default: byte_rdata = '0;
        endcase
    end

    // R9: never two destinations at once, nothing outside an access
    assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, fm_cs, psg_we, mbus_req}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !(ram_cs || fm_cs || psg_we || mbus_req));

    // R4: an unacknowledged request keeps its address
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mbus_req && !mbus_ack) |=> (mbus_req && $stable(mbus_addr)));

    // R1: FM chip is only selected when present
    assert_fm_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fm_cs |-> fm_enable);

    // R2: PSG strobe is a single cycle and only when present
    assert_psg_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        psg_we |-> (psg_enable && cpu_wr));

    assert_psg_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (psg_we && !cpu_wide) |=> !psg_we);

    // R5: RAM select is a single cycle per byte
    assert_ram_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs && !cpu_wide) |=> !ram_cs);

endmodule

// File: tb/sndbus_decoder_tb.sv
module sndbus_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_wide = 1'b0;
    logic [15:0] cpu_rdata;
    logic        cpu_done;
    logic        fm_enable = 1'b1;
    logic        psg_enable = 1'b1;
    logic [7:0]  dbus_wdata;
    logic        ram_cs, ram_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic        fm_cs, fm_we;
    logic [1:0]  fm_addr;
    logic [7:0]  fm_rdata = 8'hA5;
    logic        psg_we;
    logic        mbus_req, mbus_we;
    logic [23:0] mbus_addr;
    logic        mbus_ack = 1'b0;
    logic [7:0]  mbus_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int bank_m = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Bench RAM: contents are a fixed function of the index
    function automatic logic [7:0] ram_pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction
    function automatic logic [7:0] mb_pat(input logic [23:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h3C;
    endfunction
    assign ram_rdata = ram_pat(ram_addr);

    sndbus_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wide(cpu_wide),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .fm_enable(fm_enable), .psg_enable(psg_enable), .dbus_wdata(dbus_wdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .fm_cs(fm_cs), .fm_we(fm_we), .fm_addr(fm_addr), .fm_rdata(fm_rdata),
        .psg_we(psg_we), .mbus_req(mbus_req), .mbus_we(mbus_we),
        .mbus_addr(mbus_addr), .mbus_ack(mbus_ack), .mbus_rdata(mbus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference decode: 0 none, 1 ram, 2 fm, 3 psg, 4 bank, 5 window
    function automatic int kind(input logic [15:0] a);
        if (a >= 16'h4000 && a <= 16'h5FFF) return 2;
        if (a == 16'h7F11 || a == 16'h7F13 || a == 16'h7F15 || a == 16'h7F17) return 3;
        if (a >= 16'h6000 && a <= 16'h60FF) return 4;
        if (a >= 16'h8000) return 5;
        if (a < 16'h4000) return 1;
        return 0;
    endfunction

    // One processor access, compared on every clock against the model
    task automatic access(input bit we, input bit wide, input logic [15:0] a,
                          input logic [15:0] wd, input int stall, input string req);
        logic [15:0] exp_rd;
        exp_rd = '0;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = wd; cpu_wide = wide;
        cpu_rd = !we; cpu_wr = we;
        for (int b = 0; b < (wide ? 2 : 1); b++) begin
            logic [15:0] ba;
            logic [7:0]  wb;
            logic [7:0]  rb;
            logic [23:0] ma;
            int k;
            ba = a + 16'(b);
            wb = b ? wd[15:8] : wd[7:0];
            k  = kind(ba);
            ma = {bank_m[8:0], ba[14:0]};
            rb = '0;
            for (int c = 0; c <= stall; c++) begin
                @(negedge clk);
                mbus_ack = 1'b0;
                chk({req, " R8 done low during byte"}, cpu_done, 0);
                chk({req, " R9 selects"}, {ram_cs, fm_cs, psg_we, mbus_req},
                    {k == 1, k == 2 && fm_enable, k == 3 && we && psg_enable, k == 5});
                if (we && k != 0) chk({req, " R7 write byte"}, dbus_wdata, wb);
                if (k == 1) begin
                    chk({req, " R5 ram index"}, ram_addr, ba[12:0]);
                    chk({req, " R5 ram we"}, ram_we, we);
                    rb = ram_pat(ba[12:0]);
                end
                if (k == 2) begin
                    chk({req, " R1 fm we"}, fm_we, we && fm_enable);
                    if (fm_enable) chk({req, " R1 fm port"}, fm_addr, ba[1:0]);
                    rb = fm_enable ? fm_rdata : 8'h00;
                end
                if (k == 5) begin
                    chk({req, " R4 window address"}, mbus_addr, ma);
                    chk({req, " R4 window we"}, mbus_we, we);
                    if (c == stall) begin
                        mbus_ack = 1'b1;
                        mbus_rdata = mb_pat(ma);
                        rb = mbus_rdata;
                    end
                end else begin
                    if (k == 4 && we) bank_m = {wb[0], bank_m[8:1]};
                    break;
                end
            end
            if (b == 0) exp_rd[7:0] = rb; else exp_rd[15:8] = rb;
        end
        @(negedge clk);
        mbus_ack = 1'b0;
        chk({req, " R8 done pulse"}, cpu_done, 1);
        if (!we) chk({req, " R7 read data"}, cpu_rdata, exp_rd);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        chk({req, " R8 done dropped"}, cpu_done, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        chk("R9 reset selects", {ram_cs, fm_cs, psg_we, mbus_req, cpu_done}, 0);
        access(0, 0, 16'h8000, 0, 0, "R3 reset bank window");
        // RAM and mirror
        access(0, 0, 16'h0123, 0, 0, "R5 ram read");
        access(0, 0, 16'h2123, 0, 0, "R5 ram mirror");
        access(1, 0, 16'h3FFF, 16'h005A, 0, "R5 ram write");
        // FM enabled / disabled
        access(0, 0, 16'h4001, 0, 0, "R1 fm read on");
        access(1, 0, 16'h5FFE, 16'h0077, 0, "R1 fm write on");
        fm_enable = 1'b0;
        access(0, 0, 16'h4002, 0, 0, "R1 fm read off");
        access(1, 0, 16'h4003, 16'h0011, 0, "R1 fm write off");
        fm_enable = 1'b1;
        // PSG
        for (int i = 0; i < 4; i++)
            access(1, 0, 16'h7F11 + 16'(2*i), 16'h0090, 0, "R2 psg write");
        access(1, 0, 16'h7F19, 16'h0090, 0, "R2 psg neighbour");
        access(1, 0, 16'h7F10, 16'h0090, 0, "R2 psg even");
        access(0, 0, 16'h7F11, 0, 0, "R2 psg read zero");
        psg_enable = 1'b0;
        access(1, 0, 16'h7F15, 16'h0090, 0, "R2 psg off");
        psg_enable = 1'b1;
        // Unmapped reads
        access(0, 0, 16'h6000, 0, 0, "R6 bank page read");
        access(0, 0, 16'h7000, 0, 0, "R6 unmapped read");
        // Serial bank load: nine bits
        for (int i = 0; i < 9; i++)
            access(1, 0, 16'h60A0, {15'd0, 1'((9'h1B5 >> i) & 1)}, 0, "R3 bank shift");
        access(0, 0, 16'h8000, 0, 0, "R4 window low");
        access(0, 0, 16'hFFFF, 0, 3, "R4 window stall");
        access(1, 0, 16'hC234, 16'h00E1, 2, "R4 window write");
        access(1, 0, 16'h6055, 16'h0000, 0, "R3 bank shift zero");
        access(0, 0, 16'h9000, 0, 1, "R4 window after shift");
        // Wide accesses
        access(0, 1, 16'h1000, 0, 0, "R7 wide ram read");
        access(1, 1, 16'h5FFF, 16'h0135, 0, "R7 wide fm then bank");
        access(0, 1, 16'hFFFF, 0, 2, "R7 wide wrap");
        access(0, 1, 16'h3FFF, 0, 0, "R7 wide ram to fm");
        access(0, 0, 16'hA000, 0, 0, "R3 bank after wide");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule